// File: doc/BRIEF.md
# Table-Access Program Memory Bridge

This block lets a 16-bit data path read and write a program memory whose words are 24 bits wide. A request carries one of four operations (read the low half, read the high part, write the low half, write the high part), a byte/word size flag, a 16-bit effective address, an 8-bit page value and 16 bits of write data. The bridge joins the page and the effective address into one memory address, reads or writes the selected byte lanes of an internal synchronous array, and hands back a 16-bit result together with an error flag and a one-cycle completion pulse.

Program words sit two effective-address units apart, so effective-address bit 0 never selects a word; it acts as a byte select inside the word. The top eight bits of each word form the "high part"; above them is a phantom byte that always reads as zero and cannot be written. When page bit 7 is set, the request targets configuration space: a small read-only area whose words are generated from a base constant. Writes there are refused and flagged.

Top module: `tblmem_bridge`

## Requirements
- R1: The user word index is the low MEM_AW bits (default 8) of the concatenation of page bits 6:0 (upper) and effective-address bits 15:1 (lower); effective-address bit 0 never changes which word is reached, and pages that differ only above the index bits reach the same word.
- R2: A word-size read-low (op 0, size flag 0) returns word bits 15:0 on rsp_data.
- R3: A byte-size read-low (op 0, size flag 1) returns word bits 15:8 when effective-address bit 0 is 1 and bits 7:0 when it is 0, in rsp_data 7:0 with rsp_data 15:8 zero.
- R4: A word-size read-high (op 1, size flag 0) returns word bits 23:16 in rsp_data 7:0 and zero in rsp_data 15:8, whatever effective-address bit 0 is.
- R5: A byte-size read-high (op 1, size flag 1) returns word bits 23:16 in rsp_data 7:0 when effective-address bit 0 is 0, and all zeros when it is 1.
- R6: A write-low (op 2) in word size stores write data 15:0 into word bits 15:0; in byte size it stores write data 7:0 into word bits 15:8 when effective-address bit 0 is 1 and into bits 7:0 when it is 0. Other bits keep their value and the write result data is zero.
- R7: A write-high (op 3) stores write data 7:0 into word bits 23:16 in word size, and in byte size when effective-address bit 0 is 0; a byte-size write-high with bit 0 at 1 changes nothing.
- R8: A write with page bit 7 at 1 leaves every memory word unchanged and completes with rsp_err at 1 and rsp_data zero.
- R9: A read with page bit 7 at 1 reads configuration word k = CFG_BASE + k (default CFG_BASE 24'h0A5100, CFG_DEPTH 4) when page bits 6:0 are zero and k = effective-address bits 15:1 is below CFG_DEPTH, and reads zero otherwise; reads never set rsp_err.
- R10: cmd_ready is high when idle; a request is taken on an edge where cmd_valid and cmd_ready are both high, cmd_ready is low in the following cycle, and rsp_done is high for exactly one cycle, in the second cycle after the accepting edge, with rsp_data and rsp_err valid and held until the next completion.
- R11: After reset cmd_ready is 1 and rsp_done, rsp_err and rsp_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Bridge can take a request |
| cmd_op | input | 2 | 0 read-low, 1 read-high, 2 write-low, 3 write-high |
| cmd_byte | input | 1 | 1 for byte size, 0 for word size |
| cmd_ea | input | 16 | Effective address; bit 0 is the byte select |
| cmd_page | input | 8 | Page value; bit 7 selects configuration space |
| cmd_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Refused configuration write |
| rsp_data | output | 16 | Read result, zero for writes |

## Verification
The hardest case to reach is proving that a refused configuration write left memory intact, since the configuration index aliases the same user word that the write would otherwise have hit. The stimulus first fills a user word through every lane, then issues word writes to that same effective address with page bit 7 set, and reads the word back through both the low and the high paths with page bit 7 clear. Phantom-byte writes and byte-lane writes are followed the same way by full-word reads, so any stray lane enable shows at the data output.

// File: rtl/tblmem_pkg.sv
package tblmem_pkg;

   typedef enum logic [1:0] {
      OP_RD_LO = 2'd0,
      OP_RD_HI = 2'd1,
      OP_WR_LO = 2'd2,
      OP_WR_HI = 2'd3
   } tbl_op_e;

   localparam int BYTE_W = 8;

endpackage

// File: rtl/tblmem_decode.sv
module tblmem_decode
   import tblmem_pkg::*;
#(
   parameter int PAGE_W    = 8,
   parameter int EA_W      = 16,
   parameter int DW        = 16,
   parameter int PW        = 24,
   parameter int MEM_AW    = 8,
   parameter int CFG_DEPTH = 4,
   localparam int LANES    = PW / BYTE_W,
   localparam int CFG_AW   = (CFG_DEPTH > 1) ? $clog2(CFG_DEPTH) : 1
) (
   input  logic              fire,
   input  tbl_op_e           op,
   input  logic              byte_sz,
   input  logic [EA_W-1:0]   ea,
   input  logic [PAGE_W-1:0] page,
   input  logic [DW-1:0]     wdata,
   output logic [MEM_AW-1:0] idx,
   output logic              cfg_sel,
   output logic              cfg_hit,
   output logic [CFG_AW-1:0] cfg_idx,
   output logic [LANES-1:0]  lane_we,
   output logic [PW-1:0]     lane_wd,
   output logic              wr_refused
);

   localparam int FULL_W = PAGE_W - 1 + EA_W - 1;
   localparam logic [EA_W-2:0] CFG_LIM = (EA_W-1)'(CFG_DEPTH);

   logic [FULL_W-1:0] full_idx;
   logic              is_wr;
   logic              bsel;

   assign full_idx = {page[PAGE_W-2:0], ea[EA_W-1:1]};
   assign idx      = full_idx[MEM_AW-1:0];
   assign cfg_sel  = page[PAGE_W-1];
   assign cfg_hit  = (page[PAGE_W-2:0] == '0) && (ea[EA_W-1:1] < CFG_LIM);
   assign cfg_idx  = ea[CFG_AW:1];
   assign bsel     = ea[0];
   assign is_wr    = (op == OP_WR_LO) || (op == OP_WR_HI);

   assign wr_refused = fire && is_wr && cfg_sel;

   // high lane and lane 0 always take the low data byte; lane 1 takes the
   // low data byte for a byte write, the high data byte for a word write
   assign lane_wd = {wdata[BYTE_W-1:0],
                     byte_sz ? wdata[BYTE_W-1:0] : wdata[2*BYTE_W-1:BYTE_W],
                     wdata[BYTE_W-1:0]};

   always_comb begin
      lane_we = '0;
      if (fire && is_wr && !cfg_sel) begin
         if (op == OP_WR_LO) begin
            if (!byte_sz) begin
               lane_we[0] = 1'b1;
               lane_we[1] = 1'b1;
            end else if (bsel) begin
               lane_we[1] = 1'b1;
            end else begin
               lane_we[0] = 1'b1;
            end
         end else if (!byte_sz || !bsel) begin
            lane_we[LANES-1] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/tblmem_store.sv
module tblmem_store
   import tblmem_pkg::*;
#(
   parameter int          PW        = 24,
   parameter int          MEM_AW    = 8,
   parameter int          CFG_DEPTH = 4,
   parameter logic [23:0] CFG_BASE  = 24'h0A5100,
   localparam int LANES  = PW / BYTE_W,
   localparam int DEPTH  = 1 << MEM_AW,
   localparam int CFG_AW = (CFG_DEPTH > 1) ? $clog2(CFG_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [MEM_AW-1:0] idx,
   input  logic              cfg_sel,
   input  logic              cfg_hit,
   input  logic [CFG_AW-1:0] cfg_idx,
   input  logic [LANES-1:0]  lane_we,
   input  logic [PW-1:0]     lane_wd,
   output logic [PW-1:0]     q
);

   logic [PW-1:0] user_word;
   logic [PW-1:0] cfg_word;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [BYTE_W-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (lane_we[l]) begin
            bank[idx] <= lane_wd[l*BYTE_W +: BYTE_W];
         end
      end

      assign user_word[l*BYTE_W +: BYTE_W] = bank[idx];
   end

   assign cfg_word = cfg_hit ? (PW'(CFG_BASE) + PW'(cfg_idx)) : '0;

   always_ff @(posedge clk) begin
      if (rd_en) begin
         q <= cfg_sel ? cfg_word : user_word;
      end
   end

endmodule

// File: rtl/tblmem_format.sv
module tblmem_format
   import tblmem_pkg::*;
#(
   parameter int DW = 16,
   parameter int PW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pend,
   input  tbl_op_e       op,
   input  logic          byte_sz,
   input  logic          bsel,
   input  logic          refused,
   input  logic [PW-1:0] q,
   output logic          done,
   output logic          err,
   output logic [DW-1:0] data
);

   localparam int PAD = DW - BYTE_W;

   logic [DW-1:0] sel;

   always_comb begin
      unique case (op)
         OP_RD_LO: begin
            if (!byte_sz)  sel = q[DW-1:0];
            else if (bsel) sel = {{PAD{1'b0}}, q[2*BYTE_W-1:BYTE_W]};
            else           sel = {{PAD{1'b0}}, q[BYTE_W-1:0]};
         end
         OP_RD_HI: begin
            if (byte_sz && bsel) sel = '0;
            else                 sel = {{PAD{1'b0}}, q[PW-1:PW-BYTE_W]};
         end
         default: sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done <= 1'b0;
         err  <= 1'b0;
         data <= '0;
      end else begin
         done <= pend;
         if (pend) begin
            err  <= refused;
            data <= sel;
         end
      end
   end

endmodule

// File: rtl/tblmem_bridge.sv
module tblmem_bridge
   import tblmem_pkg::*;
#(
   parameter int          PAGE_W    = 8,
   parameter int          EA_W      = 16,
   parameter int          DW        = 16,
   parameter int          PW        = 24,
   parameter int          MEM_AW    = 8,
   parameter int          CFG_DEPTH = 4,
   parameter logic [23:0] CFG_BASE  = 24'h0A5100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_op,
   input  logic              cmd_byte,
   input  logic [EA_W-1:0]   cmd_ea,
   input  logic [PAGE_W-1:0] cmd_page,
   input  logic [DW-1:0]     cmd_wdata,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DW-1:0]     rsp_data
);

   localparam int LANES  = PW / BYTE_W;
   localparam int CFG_AW = (CFG_DEPTH > 1) ? $clog2(CFG_DEPTH) : 1;

   if (PW != DW + BYTE_W) begin : g_bad_pw
      $error("program word must be one byte wider than the data path");
   end
   if (DW != 2 * BYTE_W) begin : g_bad_dw
      $error("data path must hold exactly two byte lanes");
   end
   if (MEM_AW < 1 || MEM_AW > PAGE_W + EA_W - 2) begin : g_bad_aw
      $error("MEM_AW out of range for page and address widths");
   end
   if (CFG_DEPTH < 1 || CFG_DEPTH > (1 << (EA_W - 1))) begin : g_bad_cfg
      $error("CFG_DEPTH out of range");
   end

   tbl_op_e           op_in;
   logic              busy;
   logic              fire;
   logic [MEM_AW-1:0] idx;
   logic              cfg_sel;
   logic              cfg_hit;
   logic [CFG_AW-1:0] cfg_idx;
   logic [LANES-1:0]  lane_we;
   logic [PW-1:0]     lane_wd;
   logic              wr_refused;
   logic [PW-1:0]     q;

   logic              pend_q;
   tbl_op_e           op_q;
   logic              byte_q;
   logic              bsel_q;
   logic              refused_q;

   assign op_in     = tbl_op_e'(cmd_op);
   assign cmd_ready = !busy;
   assign fire      = cmd_valid && !busy;

   tblmem_decode #(
      .PAGE_W(PAGE_W), .EA_W(EA_W), .DW(DW), .PW(PW),
      .MEM_AW(MEM_AW), .CFG_DEPTH(CFG_DEPTH)
   ) u_decode (
      .fire       (fire),
      .op         (op_in),
      .byte_sz    (cmd_byte),
      .ea         (cmd_ea),
      .page       (cmd_page),
      .wdata      (cmd_wdata),
      .idx        (idx),
      .cfg_sel    (cfg_sel),
      .cfg_hit    (cfg_hit),
      .cfg_idx    (cfg_idx),
      .lane_we    (lane_we),
      .lane_wd    (lane_wd),
      .wr_refused (wr_refused)
   );

   tblmem_store #(
      .PW(PW), .MEM_AW(MEM_AW), .CFG_DEPTH(CFG_DEPTH), .CFG_BASE(CFG_BASE)
   ) u_store (
      .clk     (clk),
      .rd_en   (fire),
      .idx     (idx),
      .cfg_sel (cfg_sel),
      .cfg_hit (cfg_hit),
      .cfg_idx (cfg_idx),
      .lane_we (lane_we),
      .lane_wd (lane_wd),
      .q       (q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         pend_q    <= 1'b0;
         op_q      <= OP_RD_LO;
         byte_q    <= 1'b0;
         bsel_q    <= 1'b0;
         refused_q <= 1'b0;
      end else begin
         pend_q <= fire;
         if (fire) begin
            busy      <= 1'b1;
            op_q      <= op_in;
            byte_q    <= cmd_byte;
            bsel_q    <= cmd_ea[0];
            refused_q <= wr_refused;
         end else if (pend_q) begin
            busy <= 1'b0;
         end
      end
   end

   tblmem_format #(.DW(DW), .PW(PW)) u_format (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend    (pend_q),
      .op      (op_q),
      .byte_sz (byte_q),
      .bsel    (bsel_q),
      .refused (refused_q),
      .q       (q),
      .done    (rsp_done),
      .err     (rsp_err),
      .data    (rsp_data)
   );

endmodule

// File: rtl/tblmem_bridge_chk.sv
module tblmem_bridge_chk #(
   parameter int PAGE_W = 8,
   parameter int DW     = 16,
   parameter int LANES  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [1:0]        cmd_op,
   input logic              cmd_byte,
   input logic [PAGE_W-1:0] cmd_page,
   input logic              rsp_done,
   input logic              rsp_err,
   input logic [DW-1:0]     rsp_data,
   input logic [LANES-1:0]  lane_we
);

   logic acc;
   assign acc = cmd_valid && cmd_ready;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R10

   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !cmd_ready); // R10

   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> ##1 rsp_done); // R10

   AST_CFG_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op[1] && cmd_page[PAGE_W-1]) |=> ##1 (rsp_done && rsp_err)); // R8

   AST_CFG_NO_LANE_WE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_page[PAGE_W-1] |-> (lane_we == '0)); // R8

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !($past(cmd_op, 2) == 2'd0 && !$past(cmd_byte, 2)))
      |-> (rsp_data[DW-1:8] == '0)); // R5

   AST_WRITE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && $past(cmd_op[1], 2)) |-> (rsp_data == '0)); // R6

   AST_READ_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && !$past(cmd_op[1], 2)) |-> !rsp_err); // R9

endmodule

bind tblmem_bridge tblmem_bridge_chk #(
   .PAGE_W(PAGE_W), .DW(DW), .LANES(LANES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_op    (cmd_op),
   .cmd_byte  (cmd_byte),
   .cmd_page  (cmd_page),
   .rsp_done  (rsp_done),
   .rsp_err   (rsp_err),
   .rsp_data  (rsp_data),
   .lane_we   (lane_we)
);

// File: tb/tblmem_bridge_test.sv
`timescale 1ns/1ps
module tblmem_bridge_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [1:0]  cmd_op = 2'd0;
   logic        cmd_byte = 1'b0;
   logic [15:0] cmd_ea = '0;
   logic [7:0]  cmd_page = '0;
   logic [15:0] cmd_wdata = '0;
   logic        rsp_done;
   logic        rsp_err;
   logic [15:0] rsp_data;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   tblmem_bridge uut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_ea(cmd_ea),
      .cmd_page(cmd_page), .cmd_wdata(cmd_wdata),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_data(rsp_data)
   );

   // {op, byte, page, ea, wdata, exp_err, exp_data}
   localparam int NV = 27;
   localparam logic [59:0] VEC [NV] = '{
      {2'd2, 1'b0, 8'h00, 16'h0010, 16'hBEEF, 1'b0, 16'h0000},
      {2'd3, 1'b0, 8'h00, 16'h0010, 16'h1234, 1'b0, 16'h0000},
      {2'd0, 1'b0, 8'h00, 16'h0010, 16'h0000, 1'b0, 16'hBEEF},
      {2'd1, 1'b0, 8'h00, 16'h0010, 16'h0000, 1'b0, 16'h0034},
      {2'd0, 1'b1, 8'h00, 16'h0011, 16'h0000, 1'b0, 16'h00BE},
      {2'd0, 1'b1, 8'h00, 16'h0010, 16'h0000, 1'b0, 16'h00EF},
      {2'd1, 1'b1, 8'h00, 16'h0010, 16'h0000, 1'b0, 16'h0034},
      {2'd1, 1'b1, 8'h00, 16'h0011, 16'h0000, 1'b0, 16'h0000},
      {2'd2, 1'b1, 8'h00, 16'h0011, 16'h77A5, 1'b0, 16'h0000},
      {2'd3, 1'b1, 8'h00, 16'h0011, 16'h0099, 1'b0, 16'h0000},
      {2'd0, 1'b0, 8'h00, 16'h0010, 16'h0000, 1'b0, 16'hA5EF},
      {2'd1, 1'b0, 8'h00, 16'h0011, 16'h0000, 1'b0, 16'h0034},
      {2'd2, 1'b0, 8'h80, 16'h0010, 16'hFFFF, 1'b1, 16'h0000},
      {2'd3, 1'b0, 8'h80, 16'h0010, 16'h0055, 1'b1, 16'h0000},
      {2'd0, 1'b0, 8'h00, 16'h0010, 16'h0000, 1'b0, 16'hA5EF},
      {2'd1, 1'b0, 8'h00, 16'h0010, 16'h0000, 1'b0, 16'h0034},
      {2'd0, 1'b0, 8'h80, 16'h0002, 16'h0000, 1'b0, 16'h5101},
      {2'd1, 1'b0, 8'h80, 16'h0002, 16'h0000, 1'b0, 16'h000A},
      {2'd0, 1'b1, 8'h80, 16'h0001, 16'h0000, 1'b0, 16'h0051},
      {2'd0, 1'b0, 8'h80, 16'h0010, 16'h0000, 1'b0, 16'h0000},
      {2'd0, 1'b0, 8'h81, 16'h0000, 16'h0000, 1'b0, 16'h0000},
      {2'd2, 1'b1, 8'h00, 16'h0010, 16'hFF3C, 1'b0, 16'h0000},
      {2'd3, 1'b1, 8'h00, 16'h0010, 16'hAB61, 1'b0, 16'h0000},
      {2'd0, 1'b0, 8'h01, 16'h0010, 16'h0000, 1'b0, 16'hA53C},
      {2'd1, 1'b0, 8'h00, 16'h0010, 16'h0000, 1'b0, 16'h0061},
      {2'd2, 1'b0, 8'h00, 16'h0021, 16'h0F0F, 1'b0, 16'h0000},
      {2'd0, 1'b0, 8'h00, 16'h0020, 16'h0000, 1'b0, 16'h0F0F}
   };

   task automatic check(input logic ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   function automatic string tag_of(input logic [1:0] op, input logic bt,
                                    input logic [7:0] pg);
      if (pg[7])            return op[1] ? "R8" : "R9";
      if (pg[6:0] != 7'd0)  return "R1";
      case ({op, bt})
         3'b000:  return "R2";
         3'b001:  return "R3";
         3'b010:  return "R4";
         3'b011:  return "R5";
         3'b100, 3'b101: return "R6";
         default: return "R7";
      endcase
   endfunction

   // one request; handshake timing checked under R10
   task automatic do_op(input logic [1:0] op, input logic bt,
                        input logic [7:0] pg, input logic [15:0] ea,
                        input logic [15:0] wd, input logic exp_err,
                        input logic [15:0] exp_data, input string tag);
      @(negedge clk);
      check(cmd_ready == 1'b1, "R10 ready idle", 32'(cmd_ready), 32'd1);
      cmd_op = op; cmd_byte = bt; cmd_page = pg; cmd_ea = ea; cmd_wdata = wd;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(cmd_ready == 1'b0 && rsp_done == 1'b0, "R10 busy",
            {30'd0, cmd_ready, rsp_done}, 32'd0);
      @(negedge clk);
      check(rsp_done == 1'b1, "R10 done", 32'(rsp_done), 32'd1);
      check(rsp_data == exp_data && rsp_err == exp_err, tag,
            {15'd0, rsp_err, rsp_data}, {15'd0, exp_err, exp_data});
      @(negedge clk);
      check(rsp_done == 1'b0 && rsp_data == exp_data, "R10 pulse/hold",
            {15'd0, rsp_done, rsp_data}, {16'd0, exp_data});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check(cmd_ready == 1'b1 && rsp_done == 1'b0 && rsp_err == 1'b0 && rsp_data == 16'd0,
            "R11", {13'd0, cmd_ready, rsp_done, rsp_err, rsp_data}, 32'h0004_0000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(cmd_ready == 1'b1 && rsp_done == 1'b0, "R11 after release",
            {30'd0, cmd_ready, rsp_done}, 32'd2);

      for (int i = 0; i < NV; i++) begin
         logic [59:0] v;
         v = VEC[i];
         do_op(v[59:58], v[57], v[56:49], v[48:33], v[32:17], v[16], v[15:0],
               tag_of(v[59:58], v[57], v[56:49]));
      end

      // R10: with no request, no completion appears
      repeat (5) begin
         @(negedge clk);
         check(rsp_done == 1'b0 && cmd_ready == 1'b1, "R10 idle",
               {30'd0, rsp_done, cmd_ready}, 32'd1);
      end

      // R8 corner: refused byte writes to both lanes, then full readback
      do_op(2'd2, 1'b1, 8'h80, 16'h0021, 16'h00AA, 1'b1, 16'h0000, "R8");
      do_op(2'd2, 1'b1, 8'h80, 16'h0020, 16'h00AA, 1'b1, 16'h0000, "R8");
      do_op(2'd0, 1'b0, 8'h00, 16'h0020, 16'h0000, 1'b0, 16'h0F0F, "R8");

      // R7 corner: phantom write after a known high byte
      do_op(2'd3, 1'b0, 8'h00, 16'h0020, 16'h00C7, 1'b0, 16'h0000, "R7");
      do_op(2'd3, 1'b1, 8'h00, 16'h0021, 16'h0011, 1'b0, 16'h0000, "R7");
      do_op(2'd1, 1'b1, 8'h00, 16'h0020, 16'h0000, 1'b0, 16'h00C7, "R7");
      do_op(2'd0, 1'b0, 8'h00, 16'h0020, 16'h0000, 1'b0, 16'h0F0F, "R7");

      // R9 corner: last and first-missing configuration words
      do_op(2'd0, 1'b0, 8'h80, 16'h0006, 16'h0000, 1'b0, 16'h5103, "R9");
      do_op(2'd0, 1'b0, 8'h80, 16'h0008, 16'h0000, 1'b0, 16'h0000, "R9");

      summary();
   end

endmodule